// File: doc/BRIEF.md
# Single-Shot Conversion Arbiter with Byte Register Bank

This block is the register front of a multiplexed analog-to-digital converter. Software reaches it over a plain byte bus with an address, a write strobe and write data, and reads come back combinationally on a read-data port. It sets up one conversion at a time. One register holds the analog channel and the premux scaling. Another holds the reference-pair selector. Two more hold the analog and digital parameter bytes, and the digital byte carries the decimation code. The block then launches the converter when software sets enable and request together.

A state machine with the states `ST_IDLE`, `ST_LAUNCH` and `ST_BUSY` runs each conversion. It has these transitions:
- **accept**: `ST_IDLE`→`ST_LAUNCH`, when the pending request is legal.
- **reject**: stays in `ST_IDLE` and sets the sticky error bit.
- **go**: `ST_LAUNCH`→`ST_BUSY`.
- **abort**: `ST_LAUNCH`/`ST_BUSY`→`ST_IDLE`, when the arbiter is disabled.
- **finish**: `ST_BUSY`→`ST_IDLE`, on the converter's done pulse.

On finish the 16-bit result is latched into a low-byte and a high-byte register, end-of-conversion is set and the interrupt pulses for one cycle. Software forms the value as high×256+low.

The byte addresses are: 0 control, 1 mux, 2 analog parameter, 3 digital parameter, 4 reference select, 5 result low, 6 result high. Other addresses read 0x00, and the two result bytes are read-only.

Top module: `conv_arbiter`

## Requirements
- R1: After reset the control byte reads 0x00, the analog parameter byte reads 0xFE, and `conv_start` and `irq` are low.
- R2: The mux byte (address 1) drives `conv_chan` from bits 7:4 and `conv_premux` from bits 3:2.
- R3: The reference byte (address 4) drives `conv_ref_sel` from bits 6:4. Selector codes 3, 6 and 7 raise `ref_bad` and control bit 4. Codes 0, 1, 2, 4 and 5 clear them.
- R4: Digital parameter bits 6:5 set `conv_decim_len` to 512, 1024, 2048 or 4096 for the codes 0 to 3.
- R5: A control write with bit 0 (enable) and bit 7 (request) set is legal when the reference code is valid and the analog byte is 0xFF. It raises `conv_start` for exactly one cycle, starting one clock after the write edge. From that cycle on, control bit 7 reads 0.
- R6: A request is rejected when the arbiter is disabled, when the reference code is invalid, or when the analog byte is not 0xFF. A rejected request gives no `conv_start` and sets control bit 5. Bit 5 stays set until a control write with bit 5 set.
- R7: A done pulse in `ST_BUSY` latches `conv_data` into address 5 (low byte) and address 6 (high byte) on the same edge that sets control bit 6 (end-of-conversion). On that edge `irq` goes high for one cycle.
- R8: End-of-conversion clears on a control write with bit 0 clear, and on a control write with bit 7 set.
- R9: A control write with bit 0 clear during a conversion aborts it, even in the same cycle as the done pulse. The abort latches nothing and raises no `irq`.
- R10: A done pulse while idle changes no result byte and raises no `irq`.
- R11: A request written while a conversion is in progress is dropped. After that conversion completes, no second `conv_start` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 16 | Converter result, valid with `conv_done` |
| conv_start | output | 1 | One-cycle converter launch |
| conv_chan | output | 4 | Selected analog channel |
| conv_premux | output | 2 | Premux scaling select |
| conv_ref_sel | output | 3 | Reference-pair selector |
| conv_decim_len | output | 13 | Decimation length in samples |
| ref_bad | output | 1 | Reference selector holds an illegal code |
| irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The converter's done pulse and a disabling control write can land in the same cycle. The same holds for a new request write and a conversion still in progress. The bench provokes the first case by raising `conv_done` with fresh data while it writes 0x00 to the control byte at the same clock edge. It judges the result by the absence of `irq`, by the result bytes being unchanged and by end-of-conversion staying clear. For the second case it writes a request during `ST_BUSY`, lets the conversion finish, and confirms that no further launch appears.

// File: rtl/conv_arb_pkg.sv
package conv_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2
    } arb_state_t;

    localparam int unsigned A_CTRL = 0;
    localparam int unsigned A_MUX  = 1;
    localparam int unsigned A_ANA  = 2;
    localparam int unsigned A_DIG  = 3;
    localparam int unsigned A_REF  = 4;
    localparam int unsigned A_RLO  = 5;
    localparam int unsigned A_RHI  = 6;

    localparam logic [7:0] ANA_ON_CODE  = 8'hFF;
    localparam logic [7:0] ANA_OFF_CODE = 8'hFE;

    function automatic logic ref_code_legal(input logic [2:0] code);
        return (code != 3'd3) && (code != 3'd6) && (code != 3'd7);
    endfunction

endpackage

// File: rtl/conv_arb_regs.sv
module conv_arb_regs
    import conv_arb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 8,
    localparam int RES_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] ctrl_byte,
    input  logic [RES_W-1:0]  result,
    output logic [BYTE_W-1:0] mux_q,
    output logic [BYTE_W-1:0] ana_q,
    output logic [BYTE_W-1:0] dig_q,
    output logic [BYTE_W-1:0] ref_q,
    output logic [BYTE_W-1:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_q <= '0;
            ana_q <= BYTE_W'(ANA_OFF_CODE);
            dig_q <= '0;
            ref_q <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(A_MUX)) mux_q <= wdata;
            if (addr == ADDR_W'(A_ANA)) ana_q <= wdata;
            if (addr == ADDR_W'(A_DIG)) dig_q <= wdata;
            if (addr == ADDR_W'(A_REF)) ref_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL)) rdata = ctrl_byte;
        if (addr == ADDR_W'(A_MUX))  rdata = mux_q;
        if (addr == ADDR_W'(A_ANA))  rdata = ana_q;
        if (addr == ADDR_W'(A_DIG))  rdata = dig_q;
        if (addr == ADDR_W'(A_REF))  rdata = ref_q;
        if (addr == ADDR_W'(A_RLO))  rdata = result[BYTE_W-1:0];
        if (addr == ADDR_W'(A_RHI))  rdata = result[RES_W-1:BYTE_W];
    end

    // Only the analog byte has a non-zero reset value
    assert_ana_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> ana_q == BYTE_W'(ANA_OFF_CODE));

endmodule

// File: rtl/conv_arb_decode.sv
module conv_arb_decode
    import conv_arb_pkg::*;
#(
    parameter int BASE_DECIM = 512,
    localparam int LEN_W = $clog2(BASE_DECIM * 8) + 1
) (
    input  logic [7:0]       mux_q,
    input  logic [7:0]       ana_q,
    input  logic [1:0]       decim_code,
    input  logic [2:0]       ref_code,
    output logic [3:0]       chan,
    output logic [1:0]       premux,
    output logic [2:0]       ref_sel,
    output logic             ref_bad,
    output logic             ana_on,
    output logic [LEN_W-1:0] decim_len
);

    always_comb begin
        chan      = mux_q[7:4];
        premux    = mux_q[3:2];
        ref_sel   = ref_code;
        ref_bad   = !ref_code_legal(ref_code);
        ana_on    = (ana_q == ANA_ON_CODE);
        decim_len = LEN_W'(BASE_DECIM) << decim_code;
    end

endmodule

// File: rtl/conv_arb_seq.sv
module conv_arb_seq
    import conv_arb_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             wr_en_bit,
    input  logic             wr_err_bit,
    input  logic             wr_req_bit,
    input  logic             ref_bad,
    input  logic             ana_on,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic [7:0]       ctrl_byte,
    output logic [RES_W-1:0] result,
    output logic             conv_start,
    output logic             irq
);

    arb_state_t state_q, state_d;
    logic en_q, req_q, eoc_q, err_q;
    logic kill, accept, reject, latch;

    assign kill   = ctrl_wr && !wr_en_bit;
    assign accept = (state_q == ST_IDLE) && req_q && en_q && !ref_bad && ana_on;
    assign reject = (state_q == ST_IDLE) && req_q && !(en_q && !ref_bad && ana_on);
    assign latch  = (state_q == ST_BUSY) && conv_done && en_q && !kill;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = (!en_q || kill) ? ST_IDLE : ST_BUSY;
            ST_BUSY:   if (!en_q || kill || conv_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            req_q  <= 1'b0;
            eoc_q  <= 1'b0;
            err_q  <= 1'b0;
            result <= '0;
            irq    <= 1'b0;
        end else begin
            if (ctrl_wr) en_q <= wr_en_bit;
            if (ctrl_wr && wr_req_bit && state_q == ST_IDLE && !req_q)
                req_q <= 1'b1;
            else if (state_q == ST_IDLE)
                req_q <= 1'b0;
            if (ctrl_wr && (!wr_en_bit || wr_req_bit))
                eoc_q <= 1'b0;
            else if (latch)
                eoc_q <= 1'b1;
            if (reject)
                err_q <= 1'b1;
            else if (ctrl_wr && wr_err_bit)
                err_q <= 1'b0;
            if (latch) result <= conv_data;
            irq <= latch;
        end
    end

    assign conv_start = (state_q == ST_LAUNCH);
    assign ctrl_byte  = {req_q, eoc_q, err_q, ref_bad, 3'b000, en_q};

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_start_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(en_q));
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_with_eoc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eoc_q);
    assert_eoc_off_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_en_bit) |=> (!eoc_q && !irq));
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(ctrl_wr && wr_err_bit)) |=> err_q);
    assert_idle_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(result));

endmodule

// File: rtl/conv_arbiter.sv
module conv_arbiter
    import conv_arb_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int BASE_DECIM = 512,
    localparam int LEN_W     = $clog2(BASE_DECIM * 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              conv_done,
    input  logic [15:0]       conv_data,
    output logic              conv_start,
    output logic [3:0]        conv_chan,
    output logic [1:0]        conv_premux,
    output logic [2:0]        conv_ref_sel,
    output logic [LEN_W-1:0]  conv_decim_len,
    output logic              ref_bad,
    output logic              irq
);

    logic [7:0]  mux_q, ana_q, dig_q, ref_q, ctrl_byte;
    logic [15:0] result;
    logic        ana_on, ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));

    conv_arb_regs #(.ADDR_W(ADDR_W), .BYTE_W(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .ctrl_byte(ctrl_byte), .result(result),
        .mux_q(mux_q), .ana_q(ana_q), .dig_q(dig_q), .ref_q(ref_q),
        .rdata(bus_rdata)
    );

    conv_arb_decode #(.BASE_DECIM(BASE_DECIM)) u_decode (
        .mux_q(mux_q), .ana_q(ana_q), .decim_code(dig_q[6:5]),
        .ref_code(ref_q[6:4]), .chan(conv_chan), .premux(conv_premux),
        .ref_sel(conv_ref_sel), .ref_bad(ref_bad), .ana_on(ana_on),
        .decim_len(conv_decim_len)
    );

    conv_arb_seq #(.RES_W(16)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .wr_en_bit(bus_wdata[0]), .wr_err_bit(bus_wdata[5]),
        .wr_req_bit(bus_wdata[7]), .ref_bad(ref_bad), .ana_on(ana_on),
        .conv_done(conv_done), .conv_data(conv_data),
        .ctrl_byte(ctrl_byte), .result(result),
        .conv_start(conv_start), .irq(irq)
    );

endmodule

// File: tb/conv_arbiter_bench.sv
module conv_arbiter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_start, ref_bad, irq;
    logic [3:0]  conv_chan;
    logic [1:0]  conv_premux;
    logic [2:0]  conv_ref_sel;
    logic [12:0] conv_decim_len;

    int checks = 0;
    int fails = 0;
    int starts = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    conv_arbiter u_conv_arbiter (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done(conv_done),
        .conv_data(conv_data), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_premux(conv_premux), .conv_ref_sel(conv_ref_sel),
        .conv_decim_len(conv_decim_len), .ref_bad(ref_bad), .irq(irq)
    );

    always @(posedge clk) if (conv_start) starts++;

    typedef struct packed {
        logic [7:0]  mux;
        logic [7:0]  dig;
        logic [7:0]  refb;
        logic [15:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'hF4, 8'h00, 8'h10, 16'h1234},
        '{8'h08, 8'h20, 8'h00, 16'hFFFF},
        '{8'h5C, 8'h40, 8'hA0, 16'h0001},
        '{8'hA0, 8'h60, 8'hC0, 16'h8000},
        '{8'h3C, 8'hE3, 8'h50, 16'h00FF},
        '{8'hCF, 8'h1F, 8'h4F, 16'hA55A}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, lo, hi;
        int s0;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(4'd0, b); check("R1 ctrl", b, 8'h00);
        rd(4'd2, b); check("R1 ana", b, 8'hFE);
        check("R1 start", conv_start, 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R7
        foreach (VECS[i]) begin
            wr(4'd1, VECS[i].mux);
            wr(4'd3, VECS[i].dig);
            wr(4'd4, VECS[i].refb);
            wr(4'd2, 8'hFF);
            check("R2 chan", conv_chan, VECS[i].mux[7:4]);
            check("R2 premux", conv_premux, VECS[i].mux[3:2]);
            check("R3 ref_sel", conv_ref_sel, VECS[i].refb[6:4]);
            check("R3 ref_bad", ref_bad, 0);
            check("R4 decim", conv_decim_len, 512 << VECS[i].dig[6:5]);
            wr(4'd0, 8'h81);
            check("R5 no early start", conv_start, 0);
            @(negedge clk);
            check("R5 start", conv_start, 1);
            @(negedge clk);
            check("R5 start one cycle", conv_start, 0);
            rd(4'd0, b); check("R5 req cleared", b[7], 0);
            conv_done = 1'b1; conv_data = VECS[i].data;
            @(negedge clk);
            conv_done = 1'b0; conv_data = '0;
            check("R7 irq", irq, 1);
            rd(4'd0, b); check("R7 eoc", b[6], 1);
            rd(4'd5, lo); rd(4'd6, hi);
            check("R7 data", {hi, lo}, VECS[i].data);
            @(negedge clk);
            check("R7 irq one cycle", irq, 0);
        end

        // R8 eoc cleared by disable write
        wr(4'd0, 8'h00);
        rd(4'd0, b); check("R8 eoc clear on disable", b[6], 0);

        // R3 illegal codes
        for (int c = 0; c < 8; c++) begin
            wr(4'd4, 8'(c << 4));
            check("R3 ref_bad code", ref_bad, (c == 3 || c == 6 || c == 7) ? 1 : 0);
            rd(4'd0, b); check("R3 ctrl bit4", b[4], (c == 3 || c == 6 || c == 7) ? 1 : 0);
        end

        // R6 rejections
        s0 = starts;
        wr(4'd0, 8'h81);                 // ref code 7 loaded
        repeat (3) @(negedge clk);
        rd(4'd0, b); check("R6 err bad ref", b[5], 1);
        check("R6 no start bad ref", starts - s0, 0);
        wr(4'd0, 8'h21);
        rd(4'd0, b); check("R6 err cleared", b[5], 0);
        wr(4'd4, 8'h10);
        wr(4'd0, 8'h80);                 // enable not set
        repeat (3) @(negedge clk);
        rd(4'd0, b); check("R6 err disabled", b[5], 1);
        wr(4'd0, 8'h21);
        wr(4'd2, 8'hFE);
        wr(4'd0, 8'h81);                 // analog off
        repeat (3) @(negedge clk);
        rd(4'd0, b); check("R6 err analog off", b[5], 1);
        check("R6 no start total", starts - s0, 0);
        wr(4'd0, 8'h21);
        wr(4'd2, 8'hFF);

        // R10 stray done while idle
        rd(4'd5, lo); rd(4'd6, hi);
        conv_done = 1'b1; conv_data = 16'h7777;
        @(negedge clk);
        conv_done = 1'b0;
        check("R10 irq", irq, 0);
        begin
            logic [7:0] lo2, hi2;
            rd(4'd5, lo2); rd(4'd6, hi2);
            check("R10 data held", {hi2, lo2}, {hi, lo});
        end

        // R9 disable in same cycle as done
        wr(4'd0, 8'h81);
        repeat (2) @(negedge clk);
        rd(4'd5, lo); rd(4'd6, hi);
        conv_done = 1'b1; conv_data = 16'hBEEF;
        wr(4'd0, 8'h00);
        conv_done = 1'b0;
        check("R9 no irq", irq, 0);
        begin
            logic [7:0] lo2, hi2;
            rd(4'd5, lo2); rd(4'd6, hi2);
            check("R9 data held", {hi2, lo2}, {hi, lo});
        end
        rd(4'd0, b); check("R9 eoc clear", b[6], 0);

        // R11 request while busy dropped; R8 eoc cleared by request
        s0 = starts;
        wr(4'd0, 8'h81);
        repeat (2) @(negedge clk);
        wr(4'd0, 8'h81);
        conv_done = 1'b1; conv_data = 16'h4242;
        @(negedge clk);
        conv_done = 1'b0;
        check("R11 irq", irq, 1);
        repeat (4) @(negedge clk);
        check("R11 single start", starts - s0, 1);
        wr(4'd0, 8'h81);
        rd(4'd0, b); check("R8 eoc clear on request", b[6], 0);
        repeat (2) @(negedge clk);
        conv_done = 1'b1; conv_data = 16'h0102;
        @(negedge clk);
        conv_done = 1'b0;
        rd(4'd5, lo); rd(4'd6, hi);
        check("R7 data after restart", {hi, lo}, 16'h0102);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule